// File: doc/BRIEF.md
# Exception Frame Push and Return Sequencer

This block runs the memory side of exception handling for a 32-bit core. When the core starts an exception entry, the block switches the status register to supervisor mode. It then uses the stack pointer that the new mode selects and stores a two-longword frame on that stack. The frame holds the return address and a packed format/status word. The block then reads the handler address from the vector table and hands it back as the new program counter. When the core starts a return, the block reads the frame back and restores the status register and the program counter. It also puts back any low stack-pointer bits that were dropped when the frame was built.

The block owns the 16-bit status register. It tells the core which stack pointer to use through a two-bit stack select, and the core feeds the selected pointer back on `sp_i`. The block also judges pending hardware interrupts. It captures the level and vector of an interrupt when the interrupt is first signalled, and it accepts the interrupt only when that level is above the current priority mask. Memory is reached through one 32-bit request/ready port, with one access in flight at a time.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset the status register reads `SR_RST` (default 0x2700), `busy_o`, `done_o` and `mem_req_o` are low, and `stk_sel_o` is 1.
- R2: The frame word has bits 31:28 = 0x4 OR'd with the misalignment bits, bits 25:16 = vector number times 4, and bits 15:0 = the status register from before the exception.
- R3: The low two bits of the stack pointer selected after the mode switch go into frame bits 29:28. All pushes use that pointer rounded down to a multiple of 4 (the base).
- R4: On entry the return address is written at base-4 and then the frame word at base-8. After that the selected stack pointer is written once with base-8 through `sp_we_o`/`sp_o`.
- R5: On entry the handler address is read as a 32-bit word at `vbr_i` + 4 × vector. It appears on `pc_o` while `done_o` is high.
- R6: On entry the supervisor bit (bit 13) is set. For a hardware entry only, the mask field (bits 10:8) takes the accepted level and the master bit (bit 12) is cleared. All other bits keep their values.
- R7: For a software entry with vector number 32 to 47 inclusive, the saved return address is `pc_i`+2. For every other vector, and for every hardware entry, it is `pc_i`.
- R8: On return the frame word is read at SP and the new PC at SP+4. The status register takes frame bits 15:0, and the stack pointer that was selected before the restore is written with (SP OR frame bits 29:28) + 8.
- R9: `irq_ok_o` is high only while a captured interrupt level is strictly greater than the status mask. A hardware entry start while `irq_ok_o` is low is ignored and changes no state.
- R10: The level and vector of a hardware interrupt are captured when `pend_valid_i` rises and are held while it stays high. A hardware entry uses the captured vector and ignores `vec_num_i`.
- R11: `stk_sel_o` is 0 when bit 13 is clear, 1 when bit 13 is set and bit 12 is clear, and 2 when both are set. It follows every status register update, so the entry frame lands on the stack of the new mode.
- R12: `busy_o` is high from the cycle after an accepted start through the single cycle with `done_o` high, and low in the next cycle. A start while busy is ignored.
- R13: `mem_req_o` stays high with address, write enable and write data unchanged until `mem_rdy_i`. Every access address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one sequence |
| ret_sel_i | input | 1 | 1 selects return, 0 selects entry |
| hw_irq_i | input | 1 | Entry is for the accepted hardware interrupt |
| vec_num_i | input | VEC_W | Vector number for a software entry |
| pc_i | input | DATA_W | Current program counter |
| vbr_i | input | DATA_W | Vector table base address |
| sp_i | input | DATA_W | Value of the stack pointer chosen by `stk_sel_o` |
| pend_valid_i | input | 1 | Hardware interrupt pending |
| pend_lvl_i | input | LVL_W | Level of the pending interrupt |
| pend_vec_i | input | VEC_W | Vector of the pending interrupt |
| irq_ok_o | output | 1 | Pending interrupt may be taken |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse; `pc_o` is valid |
| pc_o | output | DATA_W | New program counter |
| sr_o | output | SR_W | Status register |
| stk_sel_o | output | 2 | Stack select (0 user, 1 interrupt, 2 master) |
| sp_we_o | output | 1 | Write strobe for the selected stack pointer |
| sp_o | output | DATA_W | New stack pointer value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | DATA_W | Byte address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid with `mem_rdy_i` |
| mem_rdy_i | input | 1 | Completes the current request |

## Verification
The bench targets the trap window edges at vectors 31, 32, 47 and 48. A wrong bound shows up as a return address off by two. A misaligned supervisor stack is entered and then returned from. A design that skips the rounding writes unaligned frames, and one that drops bits 29:28 on return leaves the stack pointer three bytes short. Hardware interrupts are offered at a level equal to the mask, below it and above it, and the vector and level inputs are changed after signalling. A design that compares with greater-or-equal, or reads the live inputs, takes the wrong interrupt or writes the wrong vector field. A stray start during a busy sequence and random ready stalls check that one sequence runs at a time and that requests are held.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

   // status register layout
   localparam int SR_S_BIT    = 13;
   localparam int SR_M_BIT    = 12;
   localparam int SR_MASK_LSB = 8;

   // frame word layout
   localparam int        FW_FMT_LSB  = 28;
   localparam logic [3:0] FW_FMT_CODE = 4'h4;
   localparam int        FW_VOFF_LSB = 16;

   typedef enum logic [1:0] {
      STK_USER   = 2'd0,
      STK_ISP    = 2'd1,
      STK_MASTER = 2'd2
   } stk_sel_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ENT_SP,
      ST_PUSH_RA,
      ST_PUSH_FW,
      ST_SP_WB,
      ST_VEC_RD,
      ST_RET_SP,
      ST_POP_FW,
      ST_POP_PC,
      ST_RET_FIN,
      ST_DONE
   } seq_st_e;

endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
   parameter int LVL_W     = 3,
   parameter int VEC_W     = 8,
   parameter bit LATCH_VEC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pend_valid_i,
   input  logic [LVL_W-1:0] pend_lvl_i,
   input  logic [VEC_W-1:0] pend_vec_i,
   input  logic [LVL_W-1:0] mask_i,
   output logic             take_o,
   output logic [LVL_W-1:0] lvl_o,
   output logic [VEC_W-1:0] vec_o
);

   logic cap_vld;

   generate
      if (LATCH_VEC) begin : g_latch
         logic [LVL_W-1:0] lvl_q;
         logic [VEC_W-1:0] vec_q;
         logic             vld_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               lvl_q <= '0;
               vec_q <= '0;
            end else if (!pend_valid_i) begin
               vld_q <= 1'b0;
            end else if (!vld_q) begin
               vld_q <= 1'b1;
               lvl_q <= pend_lvl_i;
               vec_q <= pend_vec_i;
            end
         end

         assign cap_vld = vld_q;
         assign lvl_o   = lvl_q;
         assign vec_o   = vec_q;
      end else begin : g_live
         assign cap_vld = pend_valid_i;
         assign lvl_o   = pend_lvl_i;
         assign vec_o   = pend_vec_i;
      end
   endgenerate

   assign take_o = cap_vld && (lvl_o > mask_i);

endmodule

// File: rtl/exc_frame_build.sv
module exc_frame_build
   import exc_seq_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int VEC_W     = 8,
   parameter int LVL_W     = 3,
   parameter int SR_W      = 16,
   parameter int TRAP_BASE = 32,
   parameter int TRAP_CNT  = 16,
   parameter int PC_STEP   = 2
) (
   // inputs sampled at the start of an entry
   input  logic [SR_W-1:0]   cur_sr_i,
   input  logic              hw_i,
   input  logic [LVL_W-1:0]  lvl_i,
   input  logic [VEC_W-1:0]  vec_i,
   input  logic [DATA_W-1:0] pc_i,
   output logic [SR_W-1:0]   new_sr_o,
   output logic [DATA_W-1:0] ret_addr_o,
   // inputs once the new stack is visible
   input  logic [SR_W-1:0]   saved_sr_i,
   input  logic [VEC_W-1:0]  saved_vec_i,
   input  logic [1:0]        sp_low_i,
   output logic [DATA_W-1:0] frame_o
);

   localparam int VOFF_W = VEC_W + 2;

   logic is_trap;

   always_comb begin
      is_trap = (int'(vec_i) >= TRAP_BASE) && (int'(vec_i) < TRAP_BASE + TRAP_CNT);
      ret_addr_o = (is_trap && !hw_i) ? pc_i + DATA_W'(PC_STEP) : pc_i;
   end

   always_comb begin
      new_sr_o = cur_sr_i;
      new_sr_o[SR_S_BIT] = 1'b1;
      if (hw_i) begin
         new_sr_o[SR_MASK_LSB +: LVL_W] = lvl_i;
         new_sr_o[SR_M_BIT] = 1'b0;
      end
   end

   always_comb begin
      frame_o = '0;
      frame_o[FW_FMT_LSB +: 4]       = FW_FMT_CODE | {2'b00, sp_low_i};
      frame_o[FW_VOFF_LSB +: VOFF_W] = {saved_vec_i, 2'b00};
      frame_o[SR_W-1:0]              = saved_sr_i;
   end

endmodule

// File: rtl/exc_frame_unpack.sv
module exc_frame_unpack #(
   parameter int DATA_W = 32,
   parameter int FRAME_BYTES = 8
) (
   input  logic [DATA_W-1:0] sp_i,
   input  logic [1:0]        mis_i,
   output logic [DATA_W-1:0] sp_o
);

   always_comb begin
      sp_o = (sp_i | {{(DATA_W-2){1'b0}}, mis_i}) + DATA_W'(FRAME_BYTES);
   end

endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
   import exc_seq_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          VEC_W     = 8,
   parameter int          LVL_W     = 3,
   parameter int          SR_W      = 16,
   parameter logic [15:0] SR_RST    = 16'h2700,
   parameter int          TRAP_BASE = 32,
   parameter int          TRAP_CNT  = 16,
   parameter int          PC_STEP   = 2,
   parameter bit          LATCH_VEC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              ret_sel_i,
   input  logic              hw_irq_i,
   input  logic [VEC_W-1:0]  vec_num_i,
   input  logic [DATA_W-1:0] pc_i,
   input  logic [DATA_W-1:0] vbr_i,
   input  logic [DATA_W-1:0] sp_i,
   input  logic              pend_valid_i,
   input  logic [LVL_W-1:0]  pend_lvl_i,
   input  logic [VEC_W-1:0]  pend_vec_i,
   output logic              irq_ok_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] pc_o,
   output logic [SR_W-1:0]   sr_o,
   output logic [1:0]        stk_sel_o,
   output logic              sp_we_o,
   output logic [DATA_W-1:0] sp_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [DATA_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_rdy_i
);

   localparam int WORD_B  = DATA_W / 8;
   localparam int FRAME_B = 2 * WORD_B;

   generate
      if (DATA_W != 32) begin : g_bad_dw
         $error("exc_frame_seq: DATA_W must be 32");
      end
      if (SR_W != 16) begin : g_bad_sr
         $error("exc_frame_seq: SR_W must be 16");
      end
      if (LVL_W != 3) begin : g_bad_lvl
         $error("exc_frame_seq: LVL_W must be 3");
      end
      if (VEC_W < 1 || VEC_W > 8) begin : g_bad_vec
         $error("exc_frame_seq: VEC_W must be 1..8");
      end
   endgenerate

   seq_st_e           state_q;
   logic [SR_W-1:0]   sr_q, old_sr_q;
   logic [DATA_W-1:0] pc_q, ra_q, sp_q, fw_q;
   logic [VEC_W-1:0]  vec_q;

   logic              irq_take;
   logic [LVL_W-1:0]  cap_lvl;
   logic [VEC_W-1:0]  cap_vec;
   logic [VEC_W-1:0]  eff_vec;
   logic [SR_W-1:0]   new_sr;
   logic [DATA_W-1:0] ret_addr, frame_w, ret_sp;
   logic              go, xfer;

   exc_irq_gate #(
      .LVL_W(LVL_W), .VEC_W(VEC_W), .LATCH_VEC(LATCH_VEC)
   ) u_irq (
      .clk          (clk),
      .rst_n        (rst_n),
      .pend_valid_i (pend_valid_i),
      .pend_lvl_i   (pend_lvl_i),
      .pend_vec_i   (pend_vec_i),
      .mask_i       (sr_q[SR_MASK_LSB +: LVL_W]),
      .take_o       (irq_take),
      .lvl_o        (cap_lvl),
      .vec_o        (cap_vec)
   );

   assign eff_vec = hw_irq_i ? cap_vec : vec_num_i;

   exc_frame_build #(
      .DATA_W(DATA_W), .VEC_W(VEC_W), .LVL_W(LVL_W), .SR_W(SR_W),
      .TRAP_BASE(TRAP_BASE), .TRAP_CNT(TRAP_CNT), .PC_STEP(PC_STEP)
   ) u_build (
      .cur_sr_i    (sr_q),
      .hw_i        (hw_irq_i),
      .lvl_i       (cap_lvl),
      .vec_i       (vec_num_i),
      .pc_i        (pc_i),
      .new_sr_o    (new_sr),
      .ret_addr_o  (ret_addr),
      .saved_sr_i  (old_sr_q),
      .saved_vec_i (vec_q),
      .sp_low_i    (sp_i[1:0]),
      .frame_o     (frame_w)
   );

   exc_frame_unpack #(
      .DATA_W(DATA_W), .FRAME_BYTES(FRAME_B)
   ) u_unpack (
      .sp_i  (sp_q),
      .mis_i (fw_q[FW_FMT_LSB +: 2]),
      .sp_o  (ret_sp)
   );

   assign go   = start_i && (state_q == ST_IDLE) &&
                 (ret_sel_i || !hw_irq_i || irq_take);
   assign xfer = mem_req_o && mem_rdy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         sr_q     <= SR_RST;
         old_sr_q <= '0;
         pc_q     <= '0;
         ra_q     <= '0;
         sp_q     <= '0;
         fw_q     <= '0;
         vec_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (go) begin
                  if (ret_sel_i) begin
                     state_q <= ST_RET_SP;
                  end else begin
                     old_sr_q <= sr_q;
                     sr_q     <= new_sr;
                     ra_q     <= ret_addr;
                     vec_q    <= eff_vec;
                     state_q  <= ST_ENT_SP;
                  end
               end
            end
            ST_ENT_SP: begin
               sp_q    <= {sp_i[DATA_W-1:2], 2'b00};
               fw_q    <= frame_w;
               state_q <= ST_PUSH_RA;
            end
            ST_PUSH_RA: if (xfer) state_q <= ST_PUSH_FW;
            ST_PUSH_FW: if (xfer) state_q <= ST_SP_WB;
            ST_SP_WB:   state_q <= ST_VEC_RD;
            ST_VEC_RD: begin
               if (xfer) begin
                  pc_q    <= mem_rdata_i;
                  state_q <= ST_DONE;
               end
            end
            ST_RET_SP: begin
               sp_q    <= sp_i;
               state_q <= ST_POP_FW;
            end
            ST_POP_FW: begin
               if (xfer) begin
                  fw_q    <= mem_rdata_i;
                  state_q <= ST_POP_PC;
               end
            end
            ST_POP_PC: begin
               if (xfer) begin
                  pc_q    <= mem_rdata_i;
                  state_q <= ST_RET_FIN;
               end
            end
            ST_RET_FIN: begin
               sr_q    <= fw_q[SR_W-1:0];
               state_q <= ST_DONE;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = '0;
      mem_wdata_o = '0;
      sp_we_o     = 1'b0;
      sp_o        = '0;
      unique case (state_q)
         ST_PUSH_RA: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = sp_q - DATA_W'(WORD_B);
            mem_wdata_o = ra_q;
         end
         ST_PUSH_FW: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = sp_q - DATA_W'(FRAME_B);
            mem_wdata_o = fw_q;
         end
         ST_SP_WB: begin
            sp_we_o = 1'b1;
            sp_o    = sp_q - DATA_W'(FRAME_B);
         end
         ST_VEC_RD: begin
            mem_req_o  = 1'b1;
            mem_addr_o = vbr_i + {{(DATA_W-VEC_W-2){1'b0}}, vec_q, 2'b00};
         end
         ST_POP_FW: begin
            mem_req_o  = 1'b1;
            mem_addr_o = sp_q;
         end
         ST_POP_PC: begin
            mem_req_o  = 1'b1;
            mem_addr_o = sp_q + DATA_W'(WORD_B);
         end
         ST_RET_FIN: begin
            sp_we_o = 1'b1;
            sp_o    = ret_sp;
         end
         default: ;
      endcase
   end

   always_comb begin
      if (!sr_q[SR_S_BIT])     stk_sel_o = STK_USER;
      else if (sr_q[SR_M_BIT]) stk_sel_o = STK_MASTER;
      else                     stk_sel_o = STK_ISP;
   end

   assign busy_o   = (state_q != ST_IDLE);
   assign done_o   = (state_q == ST_DONE);
   assign pc_o     = pc_q;
   assign sr_o     = sr_q;
   assign irq_ok_o = irq_take;

endmodule

// File: rtl/exc_frame_seq_chk.sv
module exc_frame_seq_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              sp_we_o,
   input logic              mem_req_o,
   input logic              mem_we_o,
   input logic [DATA_W-1:0] mem_addr_o,
   input logic [DATA_W-1:0] mem_wdata_o,
   input logic              mem_rdy_i
);

   assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                     $stable(mem_we_o) && $stable(mem_wdata_o)));

   assert_word_align_R13: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

   assert_done_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   assert_busy_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   assert_side_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o || sp_we_o) |-> busy_o);

   assert_sp_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sp_we_o |=> !sp_we_o);

endmodule

bind exc_frame_seq exc_frame_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .sp_we_o     (sp_we_o),
   .mem_req_o   (mem_req_o),
   .mem_we_o    (mem_we_o),
   .mem_addr_o  (mem_addr_o),
   .mem_wdata_o (mem_wdata_o),
   .mem_rdy_i   (mem_rdy_i)
);

// File: tb/exc_frame_seq_tb_top.sv
module exc_frame_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, ret_sel_i = 1'b0, hw_irq_i = 1'b0;
   logic [7:0]  vec_num_i = '0;
   logic [31:0] pc_i = '0, vbr_i = '0, sp_i;
   logic        pend_valid_i = 1'b0;
   logic [2:0]  pend_lvl_i = '0;
   logic [7:0]  pend_vec_i = '0;
   logic        irq_ok_o, busy_o, done_o, sp_we_o;
   logic [31:0] pc_o, sp_o, mem_addr_o, mem_wdata_o, mem_rdata_i;
   logic [15:0] sr_o;
   logic [1:0]  stk_sel_o;
   logic        mem_req_o, mem_we_o, mem_rdy_i = 1'b1;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int rdy_mode = 0;
   logic [7:0] lfsr = 8'hA5;

   logic [31:0] mem  [0:255];
   logic [31:0] bank [0:3];

   // model of the interrupt capture (R10)
   logic       m_vld = 1'b0;
   logic [2:0] m_lvl = '0;
   logic [7:0] m_vec = '0;

   always #4 clk = ~clk;

   exc_frame_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ret_sel_i(ret_sel_i),
      .hw_irq_i(hw_irq_i), .vec_num_i(vec_num_i), .pc_i(pc_i), .vbr_i(vbr_i),
      .sp_i(sp_i), .pend_valid_i(pend_valid_i), .pend_lvl_i(pend_lvl_i),
      .pend_vec_i(pend_vec_i), .irq_ok_o(irq_ok_o), .busy_o(busy_o),
      .done_o(done_o), .pc_o(pc_o), .sr_o(sr_o), .stk_sel_o(stk_sel_o),
      .sp_we_o(sp_we_o), .sp_o(sp_o), .mem_req_o(mem_req_o),
      .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
      .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i)
   );

   assign sp_i        = bank[stk_sel_o];
   assign mem_rdata_i = mem[mem_addr_o[9:2]];

   always @(posedge clk) begin
      if (mem_req_o && mem_rdy_i && mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
      if (sp_we_o) bank[stk_sel_o] <= sp_o;
      if (!rst_n) m_vld <= 1'b0;
      else if (!pend_valid_i) m_vld <= 1'b0;
      else if (!m_vld) begin
         m_vld <= 1'b1; m_lvl <= pend_lvl_i; m_vec <= pend_vec_i;
      end
   end

   always @(negedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_rdy_i <= (rdy_mode == 0) ? 1'b1 : lfsr[0];
   end

   function automatic logic [1:0] sel_of(input logic [15:0] s);
      return !s[13] ? 2'd0 : (s[12] ? 2'd2 : 2'd1);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // per-clock comparison of stack select and interrupt acceptance
   always @(negedge clk) begin
      if (rst_n) begin
         chk(stk_sel_o == sel_of(sr_o), "R11", "stk_sel", {30'd0, stk_sel_o}, {30'd0, sel_of(sr_o)});
         chk(irq_ok_o == (m_vld && (m_lvl > sr_o[10:8])), "R9", "irq_ok",
             {31'd0, irq_ok_o}, {31'd0, m_vld && (m_lvl > sr_o[10:8])});
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wait_done(input string req, input bit dbl);
      int n;
      n = 0;
      while (!done_o && n < 400) begin
         @(negedge clk);
         n++;
         if (dbl && n == 2) begin start_i = 1'b1; ret_sel_i = 1'b1; end
         else begin start_i = 1'b0; ret_sel_i = 1'b0; end
      end
      start_i = 1'b0;
      chk(done_o, req, "done seen", {31'd0, done_o}, 32'd1);
   endtask

   task automatic do_entry(input logic [31:0] pc, input logic [7:0] vec,
                           input bit hw, input bit dbl, input string req);
      logic [15:0] old_sr, new_sr;
      logic [7:0]  ev;
      logic [31:0] sp0, base, ra, fw, hnd;
      old_sr = sr_o;
      new_sr = old_sr | 16'h2000;
      if (hw) new_sr = (new_sr & ~16'h1700) | {5'd0, m_lvl, 8'd0};
      ev   = hw ? m_vec : vec;
      sp0  = bank[sel_of(new_sr)];
      base = sp0 & ~32'd3;
      ra   = (!hw && vec >= 8'd32 && vec <= 8'd47) ? pc + 32'd2 : pc;
      fw   = 32'h4000_0000 | {2'b00, sp0[1:0], 28'd0} | ({24'd0, ev} << 18) | {16'd0, old_sr};
      hnd  = mem[(vbr_i[9:0] + {ev, 2'b00}) >> 2];
      pc_i = pc; vec_num_i = vec; hw_irq_i = hw; ret_sel_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o, "R12", "busy after start", {31'd0, busy_o}, 32'd1);
      wait_done(req, dbl);
      chk(pc_o == hnd, "R5", {req, " handler"}, pc_o, hnd);
      chk(mem[(base - 32'd4) >> 2] == ra, "R7", {req, " return addr at base-4"}, mem[(base - 32'd4) >> 2], ra);
      chk(mem[(base - 32'd8) >> 2] == fw, "R2", {req, " frame word at base-8"}, mem[(base - 32'd8) >> 2], fw);
      chk(bank[sel_of(new_sr)] == base - 32'd8, "R4", {req, " stack pointer"}, bank[sel_of(new_sr)], base - 32'd8);
      chk(sr_o == new_sr, "R6", {req, " status"}, {16'd0, sr_o}, {16'd0, new_sr});
      @(negedge clk);
      chk(!busy_o && !done_o, "R12", "idle after done", {30'd0, busy_o, done_o}, 32'd0);
      hw_irq_i = 1'b0;
   endtask

   task automatic do_return(input string req);
      logic [1:0]  sel;
      logic [31:0] sp0, fw, npc, nsp;
      sel = stk_sel_o;
      sp0 = bank[sel];
      fw  = mem[sp0[9:2]];
      npc = mem[(sp0 + 32'd4) >> 2];
      nsp = (sp0 | {30'd0, fw[29:28]}) + 32'd8;
      ret_sel_i = 1'b1; hw_irq_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; ret_sel_i = 1'b0;
      wait_done(req, 1'b0);
      chk(pc_o == npc, "R8", {req, " pc"}, pc_o, npc);
      chk(sr_o == fw[15:0], "R8", {req, " status"}, {16'd0, sr_o}, {16'd0, fw[15:0]});
      chk(bank[sel] == nsp, "R8", {req, " stack pointer"}, bank[sel], nsp);
      @(negedge clk);
   endtask

   task automatic try_hw_ignored(input string req);
      logic [15:0] sr0;
      sr0 = sr_o;
      hw_irq_i = 1'b1; ret_sel_i = 1'b0; vec_num_i = 8'd3; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; hw_irq_i = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk(!busy_o && !mem_req_o, "R9", {req, " ignored start"}, {30'd0, busy_o, mem_req_o}, 32'd0);
         @(negedge clk);
      end
      chk(sr_o == sr0, "R9", {req, " status untouched"}, {16'd0, sr_o}, {16'd0, sr0});
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h8000_0000 + (i << 4);
      bank[0] = 32'h1F0; bank[1] = 32'h280; bank[2] = 32'h380; bank[3] = 32'h0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(sr_o == 16'h2700, "R1", "reset status", {16'd0, sr_o}, 32'h2700);
      chk(!busy_o && !done_o && !mem_req_o, "R1", "reset idle",
          {29'd0, busy_o, done_o, mem_req_o}, 32'd0);
      chk(stk_sel_o == 2'd1, "R1", "reset stack select", {30'd0, stk_sel_o}, 32'd1);
      rst_n = 1'b1;
      @(negedge clk);

      // plain software entry and return
      do_entry(32'h1000, 8'd5, 1'b0, 1'b0, "R4 vec5");
      do_return("R8 vec5");
      rdy_mode = 1;
      // R7 trap window edges
      do_entry(32'h2000, 8'd32, 1'b0, 1'b0, "R7 trap lo");
      do_return("R8 trap lo");
      do_entry(32'h2100, 8'd47, 1'b0, 1'b0, "R7 trap hi");
      do_return("R8 trap hi");
      do_entry(32'h2200, 8'd48, 1'b0, 1'b0, "R7 above");
      do_return("R8 above");
      do_entry(32'h2300, 8'd31, 1'b0, 1'b0, "R7 below");
      do_return("R8 below");

      // R3 misaligned supervisor stack round trip
      bank[1] = 32'h283;
      @(negedge clk);
      do_entry(32'h2400, 8'd9, 1'b0, 1'b0, "R3 misaligned");
      do_return("R3 misaligned");
      chk(bank[1] == 32'h283, "R3", "pointer restored", bank[1], 32'h283);
      bank[1] = 32'h280;

      // drop to user mode through a crafted frame (R11)
      mem[(32'h278) >> 2] = 32'h4000_0000;
      mem[(32'h27C) >> 2] = 32'h3000;
      bank[1] = 32'h278;
      @(negedge clk);
      do_return("R11 to user");
      chk(stk_sel_o == 2'd0, "R11", "user select", {30'd0, stk_sel_o}, 32'd0);
      do_entry(32'h3010, 8'd6, 1'b0, 1'b0, "R11 from user");
      do_return("R11 back to user");

      // user -> master mode with mask 2
      mem[(32'h1F0) >> 2] = 32'h4000_3200;
      mem[(32'h1F4) >> 2] = 32'h4000;
      do_return("R11 to master");
      chk(stk_sel_o == 2'd2, "R11", "master select", {30'd0, stk_sel_o}, 32'd2);

      // R10 capture then R6 hardware entry
      pend_lvl_i = 3'd5; pend_vec_i = 8'd64; pend_valid_i = 1'b1;
      repeat (2) @(negedge clk);
      pend_lvl_i = 3'd1; pend_vec_i = 8'd70;
      @(negedge clk);
      chk(irq_ok_o, "R10", "captured level accepted", {31'd0, irq_ok_o}, 32'd1);
      do_entry(32'h5000, 8'd7, 1'b1, 1'b0, "R10 hw entry");
      chk(sr_o == 16'h2500, "R6", "hw status", {16'd0, sr_o}, 32'h2500);
      pend_valid_i = 1'b0;
      @(negedge clk);

      // R9 equal and lower levels are not taken
      pend_lvl_i = 3'd5; pend_vec_i = 8'd65; pend_valid_i = 1'b1;
      repeat (2) @(negedge clk);
      try_hw_ignored("R9 equal");
      pend_valid_i = 1'b0;
      @(negedge clk);
      pend_lvl_i = 3'd4; pend_valid_i = 1'b1;
      repeat (2) @(negedge clk);
      try_hw_ignored("R9 lower");
      pend_valid_i = 1'b0;
      @(negedge clk);
      pend_lvl_i = 3'd6; pend_vec_i = 8'd66; pend_valid_i = 1'b1;
      repeat (2) @(negedge clk);
      do_entry(32'h5100, 8'd0, 1'b1, 1'b0, "R9 higher nested");
      pend_valid_i = 1'b0;
      @(negedge clk);
      do_return("R8 nested");
      do_return("R8 hw");
      chk(sr_o == 16'h3200, "R8", "status back to master", {16'd0, sr_o}, 32'h3200);

      // R12 start while busy is ignored
      do_entry(32'h6000, 8'd11, 1'b0, 1'b1, "R12 busy start");
      do_return("R12 busy start");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule